// File: doc/BRIEF.md
# Quad SPI Pseudo-Static RAM Transaction Engine

This engine sits between an on-chip requester and two 8 MB pseudo-static RAM devices that share one quad serial bus. Each accepted request moves one 32-bit word. The engine builds a complete quad-mode frame for it: an opcode, the device offset and the data, all at single data rate with one nibble on each serial clock. The engine never issues mode-change or identification commands, so both devices must already be in quad mode before the first request arrives.

Requests enter on a valid/ready channel. `req_ready` is high only while the engine is idle. A request that is presented while `req_ready` is low waits: the requester must hold `req_valid` and the request fields steady until it sees `req_ready` high at a clock edge, and that edge is the accept edge. Read results come out on a push-only channel that has no back-pressure. The consumer must take `rd_data` in the one cycle in which `rd_valid` is high.

The serial clock runs at half the system clock. One serial period is one system cycle with `sck` low, then one with `sck` high. The bus device samples a nibble on the rising edge of `sck`, and the engine captures a read nibble at the system edge that ends the `sck`-high cycle. The engine keeps programmable chip-select setup, hold and inter-frame gap times, all counted in serial-clock periods.

Top module: `qspi_ram_engine`

## Requirements
- R1: After reset, both chip selects are high, `sck` is low, `dq_oe` is low, `rd_valid` is low and `req_ready` is high.
- R2: A request is taken only at an edge where `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low until the frame and the gap after it are complete. While `req_ready` is low, changes on the request inputs have no effect on any frame.
- R3: Address bit 23 selects the device. When it is 0, `cs_n` is 2'b10 (bit 0 low). When it is 1, `cs_n` is 2'b01. At most one chip select is ever low.
- R4: A write frame has exactly 16 rising `sck` edges. The nibbles are: opcode 0x38, high nibble first; then a 24-bit device offset {1'b0, addr[22:0]}, high nibble first; then the data bytes in the order wdata[7:0], [15:8], [23:16], [31:24], each byte high nibble first.
- R5: A read frame has exactly 22 rising `sck` edges: opcode 0xEB (2 nibbles), the offset as in R4 (6 nibbles), 6 dummy clocks, then 8 data nibbles that are sampled from `dq_i`.
- R6: Read nibble n (counting from 0) becomes bits [8k+7:8k+4] of `rd_data` when n = 2k, and bits [8k+3:8k] when n = 2k+1. `rd_valid` is high for exactly one cycle: the cycle after the `sck`-high cycle of the last data nibble.
- R7: In a read frame, `dq_oe` is high for the opcode and address nibbles. It is low from the first dummy clock until the chip select rises. In a write frame, `dq_oe` is high for the whole time the chip select is low.
- R8: A chip select is low for 7 system cycles, with `sck` low, before the first `sck`-high cycle. This is the setup of 3 serial periods plus the low half of the first period.
- R9: After the last `sck`-high cycle, the chip select stays low for 6 more system cycles (3 serial periods) with `sck` low.
- R10: Between two frames, both chip selects are high for at least 4 system cycles (2 serial periods).
- R11: `sck` is high only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; a request is taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address; bit 23 selects the device |
| req_wdata | input | 32 | Write word |
| rd_valid | output | 1 | One-cycle strobe marking read data |
| rd_data | output | 32 | Read word |
| sck | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects, one per device |
| dq_o | output | 4 | Nibble driven onto the data lines |
| dq_oe | output | 1 | 1 = engine drives the data lines, 0 = high impedance |
| dq_i | input | 4 | Nibble sampled from the data lines |

## Verification
The results fall due at fixed distances from the accept edge. The chip select falls in the next cycle, and the first `sck`-high cycle comes 7 cycles later. Each further nibble follows 2 cycles after the one before it. `rd_valid` appears in the cycle after the 22nd `sck`-high cycle, and the chip select rises 6 cycles after the last `sck`-high cycle. The monitor samples every output on the falling system edge and counts cycles from the fall of the chip select. It checks setup, hold, gap and strobe position against these counts rather than waiting for events. It drives each read nibble at the falling edge of its `sck`-high cycle, so the nibble is stable at the capturing edge.

// File: rtl/qspi_ram_pkg.sv
package qspi_ram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_GAP
  } qphase_e;
endpackage

// File: rtl/qspi_frame_ctrl.sv
module qspi_frame_ctrl
  import qspi_ram_pkg::*;
#(
  parameter int SETUP_SCK   = 3,
  parameter int HOLD_SCK    = 3,
  parameter int GAP_SCK     = 2,
  parameter int HDR_SLOTS   = 8,
  parameter int DUMMY_SLOTS = 6,
  parameter int DATA_SLOTS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_rd,
  output logic ready,
  output logic cs_act,
  output logic sck,
  output logic drive_en,
  output logic shift_en,
  output logic cap_en,
  output logic cap_last
);
  localparam int RD_SLOTS = HDR_SLOTS + DUMMY_SLOTS + DATA_SLOTS;
  localparam int WR_SLOTS = HDR_SLOTS + DATA_SLOTS;
  localparam int SLOT_W   = $clog2(RD_SLOTS + 1);
  localparam int MAX_SCK  = (SETUP_SCK > HOLD_SCK) ?
                            ((SETUP_SCK > GAP_SCK) ? SETUP_SCK : GAP_SCK) :
                            ((HOLD_SCK > GAP_SCK) ? HOLD_SCK : GAP_SCK);
  localparam int CNT_W    = $clog2(2 * MAX_SCK + 1);

  qphase_e           state;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] last_slot;
  logic              half;
  logic              rd_q;
  logic              tail_hiz;

  assign last_slot = rd_q ? SLOT_W'(RD_SLOTS - 1) : SLOT_W'(WR_SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      slot  <= '0;
      half  <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_SETUP;
          cnt   <= CNT_W'(2 * SETUP_SCK - 1);
          rd_q  <= start_rd;
        end
        ST_SETUP: if (cnt == '0) begin
          state <= ST_XFER;
          slot  <= '0;
          half  <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_XFER: begin
          half <= ~half;
          if (half) begin
            if (slot == last_slot) begin
              state <= ST_HOLD;
              cnt   <= CNT_W'(2 * HOLD_SCK - 1);
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        ST_HOLD: if (cnt == '0) begin
          state <= ST_GAP;
          cnt   <= CNT_W'(2 * GAP_SCK - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_GAP: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready    = (state == ST_IDLE);
  assign cs_act   = (state == ST_SETUP) || (state == ST_XFER) || (state == ST_HOLD);
  assign sck      = (state == ST_XFER) && half;
  assign tail_hiz = rd_q && (((state == ST_XFER) && (slot >= SLOT_W'(HDR_SLOTS)))
                             || (state == ST_HOLD));
  assign drive_en = cs_act && !tail_hiz;
  assign shift_en = (state == ST_XFER) && half;
  assign cap_en   = shift_en && rd_q && (slot >= SLOT_W'(HDR_SLOTS + DUMMY_SLOTS));
  assign cap_last = cap_en && (slot == last_slot);

  // R2: once a request is taken, the engine is busy in the following cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  // R11: the serial clock only toggles inside a frame
  p_sck_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> cs_act);
endmodule

// File: rtl/qspi_nibble_path.sv
module qspi_nibble_path #(
  parameter int          ADDR_W = 24,
  parameter int          DATA_W = 32,
  parameter int          DEV_AW = 23,
  parameter logic [7:0]  RD_CMD = 8'hEB,
  parameter logic [7:0]  WR_CMD = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wr,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              cap_en,
  input  logic              cap_last,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int FRAME_W = 8 + ADDR_W + DATA_W;
  localparam int NBYTES  = DATA_W / 8;
  localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << DEV_AW) - 1'b1;

  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  cap_q;
  logic [DATA_W-1:0]  wr_bus;
  logic [ADDR_W-1:0]  dev_off;
  logic               rdv_q;

  assign dev_off = load_addr & OFF_MASK;

  // bus order: lowest byte first; each byte high nibble first
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign wr_bus[DATA_W-1-8*b -: 8] = load_data[8*b +: 8];
    assign rd_data[8*b +: 8]         = cap_q[DATA_W-1-8*b -: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cap_q <= '0;
      rdv_q <= 1'b0;
    end else begin
      if (load)
        sh_q <= load_wr ? {WR_CMD, dev_off, wr_bus} : {RD_CMD, dev_off, DATA_W'(0)};
      else if (shift_en)
        sh_q <= sh_q << 4;
      if (cap_en)
        cap_q <= {cap_q[DATA_W-5:0], dq_in};
      rdv_q <= cap_last;
    end
  end

  assign dq_out   = sh_q[FRAME_W-1 -: 4];
  assign rd_valid = rdv_q;

  // R6: read strobe lasts one cycle
  p_rdv_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/qspi_ram_engine.sv
module qspi_ram_engine #(
  parameter int         ADDR_W    = 24,
  parameter int         DATA_W    = 32,
  parameter int         NUM_DEV   = 2,
  parameter int         SETUP_SCK = 3,
  parameter int         HOLD_SCK  = 3,
  parameter int         GAP_SCK   = 2,
  parameter int         DUMMY_SCK = 6,
  parameter logic [7:0] RD_CMD    = 8'hEB,
  parameter logic [7:0] WR_CMD    = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sck,
  output logic [NUM_DEV-1:0] cs_n,
  output logic [3:0]        dq_o,
  output logic              dq_oe,
  input  logic [3:0]        dq_i
);
  localparam int DEV_BITS   = $clog2(NUM_DEV);
  localparam int DEV_AW     = ADDR_W - DEV_BITS;
  localparam int HDR_SLOTS  = (8 + ADDR_W) / 4;
  localparam int DATA_SLOTS = DATA_W / 4;

  logic                accept;
  logic                cs_act;
  logic                shift_en;
  logic                cap_en;
  logic                cap_last;
  logic [DEV_BITS-1:0] dev_q;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dev_q <= '0;
    else if (accept) dev_q <= req_addr[ADDR_W-1 -: DEV_BITS];
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
    assign cs_n[d] = !(cs_act && (dev_q == DEV_BITS'(d)));
  end

  qspi_frame_ctrl #(
    .SETUP_SCK  (SETUP_SCK),
    .HOLD_SCK   (HOLD_SCK),
    .GAP_SCK    (GAP_SCK),
    .HDR_SLOTS  (HDR_SLOTS),
    .DUMMY_SLOTS(DUMMY_SCK),
    .DATA_SLOTS (DATA_SLOTS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .start_rd(!req_write),
    .ready   (req_ready),
    .cs_act  (cs_act),
    .sck     (sck),
    .drive_en(dq_oe),
    .shift_en(shift_en),
    .cap_en  (cap_en),
    .cap_last(cap_last)
  );

  qspi_nibble_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEV_AW(DEV_AW),
    .RD_CMD(RD_CMD),
    .WR_CMD(WR_CMD)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_wr  (req_write),
    .load_addr(req_addr),
    .load_data(req_wdata),
    .shift_en (shift_en),
    .cap_en   (cap_en),
    .cap_last (cap_last),
    .dq_in    (dq_i),
    .dq_out   (dq_o),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R3: never more than one device selected
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R7: lines are released while read data is handed over
  p_rdv_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !dq_oe);

  // R10: once deselected, the bus stays idle for more than one cycle
  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n) |=> (&cs_n));

  // R8: the serial clock stays low when a select first falls
  p_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&cs_n) |-> !sck);
endmodule

// File: tb/sim_qspi_ram_engine.sv
module sim_qspi_ram_engine;
  typedef struct {
    bit          wr;
    logic [23:0] addr;
    logic [31:0] data;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        sck;
  logic [1:0]  cs_n;
  logic [3:0]  dq_o;
  logic        dq_oe;
  logic [3:0]  dq_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  txn_t        fr_q[$];
  logic [31:0] rd_q[$];

  always #5 clk = ~clk;

  qspi_ram_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sck(sck), .cs_n(cs_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'h17, a[23:16] ^ 8'hC3, a[3:0], a[7:4]};
  endfunction

  function automatic logic [3:0] nib(input logic [31:0] w, input int k);
    logic [7:0] b;
    b = w[8*(k/2) +: 8];
    return (k % 2 == 0) ? b[7:4] : b[3:0];
  endfunction

  // driver: push the expectation, then present the request until taken
  task automatic do_req(input bit wr, input logic [23:0] a, input logic [31:0] d);
    txn_t t;
    t.wr = wr; t.addr = a; t.data = d;
    fr_q.push_back(t);
    if (!wr) rd_q.push_back(pat(a));
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R2: inputs now change while busy and must not alter the frame
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
  endtask

  // monitor state
  bit          in_frame = 1'b0;
  bit          have_prev = 1'b0;
  bit          prev_sck = 1'b0;
  bit          prev_rdv = 1'b0;
  int          edges, pre, post, gap;
  logic [1:0]  cs_seen;
  logic [31:0] hdr_got, dat_got;
  bit          oe_bad;
  txn_t        cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_ready) chk(&cs_n, "R2 ready only when idle", 64'(cs_n), 64'h3);
      if (sck) chk(!(&cs_n), "R11 sck inside frame", 64'(cs_n), 64'h0);
      if (prev_rdv && rd_valid) chk(1'b0, "R6 strobe width", 64'd2, 64'd1);
      if (rd_valid) begin
        chk(in_frame && edges == 22 && post == 0, "R6 strobe position",
            64'(post), 64'd0);
        if (rd_q.size() == 0) chk(1'b0, "R6 unexpected read", 64'(rd_data), 64'd0);
        else chk(rd_data == rd_q[0], "R6 read word", 64'(rd_data), 64'(rd_q[0]));
        if (rd_q.size() != 0) void'(rd_q.pop_front());
      end
      if (!(&cs_n) && !in_frame) begin
        if (have_prev) chk(gap >= 4, "R10 gap", 64'(gap), 64'd4);
        in_frame = 1'b1;
        edges = 0; pre = 0; post = 0; oe_bad = 1'b0;
        hdr_got = '0; dat_got = '0; cs_seen = cs_n;
        if (fr_q.size() == 0) chk(1'b0, "R2 unexpected frame", 64'(cs_n), 64'h3);
        else cur = fr_q[0];
      end
      if (in_frame && !(&cs_n)) begin
        if (cs_n != cs_seen) oe_bad = 1'b1;
        if (sck && !prev_sck) begin
          if (edges < 8) hdr_got = {hdr_got[27:0], dq_o};
          else if (cur.wr && edges < 16) dat_got = {dat_got[27:0], dq_o};
          if (cur.wr && !dq_oe) oe_bad = 1'b1;
          if (!cur.wr && (edges < 8) != dq_oe) oe_bad = 1'b1;
          if (!cur.wr && edges >= 14) dq_i = nib(pat(cur.addr), edges - 14);
          edges++;
          post = 0;
        end else if (!sck) begin
          if (edges == 0) pre++;
          else post++;
          if (!cur.wr && edges >= 8 && dq_oe) oe_bad = 1'b1;
        end
      end else if (in_frame) begin
        in_frame = 1'b0;
        have_prev = 1'b1;
        gap = 1;
        chk(cs_seen == (cur.addr[23] ? 2'b01 : 2'b10), "R3 select", 64'(cs_seen),
            64'(cur.addr[23] ? 2'b01 : 2'b10));
        chk(pre == 7, "R8 setup", 64'(pre), 64'd7);
        chk(post == 6, "R9 hold", 64'(post), 64'd6);
        chk(!oe_bad, "R7 line direction", 64'(oe_bad), 64'd0);
        if (cur.wr) begin
          chk(edges == 16, "R4 edge count", 64'(edges), 64'd16);
          chk(hdr_got == {8'h38, 1'b0, cur.addr[22:0]}, "R4 header",
              64'(hdr_got), 64'({8'h38, 1'b0, cur.addr[22:0]}));
          chk(dat_got == {cur.data[7:0], cur.data[15:8], cur.data[23:16], cur.data[31:24]},
              "R4 data order", 64'(dat_got),
              64'({cur.data[7:0], cur.data[15:8], cur.data[23:16], cur.data[31:24]}));
        end else begin
          chk(edges == 22, "R5 edge count", 64'(edges), 64'd22);
          chk(hdr_got == {8'hEB, 1'b0, cur.addr[22:0]}, "R5 header",
              64'(hdr_got), 64'({8'hEB, 1'b0, cur.addr[22:0]}));
        end
        if (fr_q.size() != 0) void'(fr_q.pop_front());
      end else if (have_prev) begin
        gap++;
      end
      prev_sck = sck;
      prev_rdv = rd_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n == 2'b11 && !sck && !dq_oe && !rd_valid && req_ready, "R1 reset state",
        64'({cs_n, sck, dq_oe, rd_valid, req_ready}), 64'b110001);
    rst_n = 1'b1;
    @(negedge clk);
    do_req(1'b1, 24'h000000, 32'h12345678);
    do_req(1'b1, 24'h7FFFFF, 32'hA5F00F5A);
    do_req(1'b1, 24'h800000, 32'hDEADBEEF);
    do_req(1'b0, 24'h012345, 32'h0);
    do_req(1'b0, 24'hFFFFFF, 32'h0);
    do_req(1'b1, 24'hC0FFEE, 32'h00FF00FF);
    do_req(1'b0, 24'h3C5A69, 32'h0);
    do_req(1'b0, 24'h80A001, 32'h0);
    repeat (5) @(negedge clk);
    do_req(1'b1, 24'h456789, 32'hFFFFFFFF);
    while (fr_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(req_ready && (&cs_n), "R2 idle at end", 64'({req_ready, cs_n}), 64'b111);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule